// File: doc/BRIEF.md
# I2C Byte Master with Clock-Stretch Wait

This block is a byte-level transfer engine for a two-wire serial bus. It drives the clock and data lines as open-drain outputs. Each output enable pulls its line low, and a released line is pulled high outside the chip. The engine reads both lines back through a two-stage synchronizer. A host issues one command at a time: a start condition, a stop condition, a byte write or a byte read. The host waits for the `done` pulse before issuing the next command. Bytes can follow one another with no limit. Between commands the engine holds the clock low, so a transfer stays open until the host asks for a stop.

The bit period comes from a programmable half-period count. After releasing the clock line, the engine does not assume the line has risen. It waits until the synchronized line reads high, and only then starts counting the high phase. A slave that holds the clock low therefore freezes the bit timing, and the transfer resumes exactly where it paused. An optional watchdog flags a slave that holds the clock longer than a programmed limit.

Top module: `i2c_stretch_master`

## Requirements
- R1: A write command (cmd_op = 2) puts the 8 bits of cmd_wdata on the data line over 8 clock pulses, bit 7 first and bit 0 last.
- R2: On the ninth clock of a write, the engine releases the data line and samples it at the end of the high phase. ack_nack becomes 1 if the line was high (not acknowledged) and 0 if it was low.
- R3: A read command (cmd_op = 3) samples 8 bits with the data line released and presents them on rd_data, first bit received in bit 7. On the ninth clock the engine pulls the data line low when cmd_rd_nack = 0 and leaves it released when cmd_rd_nack = 1.
- R4: Byte commands can be chained without limit. After each byte the engine keeps the clock line pulled low until the next command.
- R5: A start command (cmd_op = 0) makes the data line fall while the clock is high. A stop command (cmd_op = 1) makes the data line rise while the clock is high. A byte command produces no data-line change while the clock is high.
- R6: After releasing the clock line, the engine waits for the line to read high. The high phase then lasts at least cfg_half_div cycles counted from that point, however long a slave held the line low.
- R7: Every low phase the engine drives on the clock line lasts at least cfg_half_div cycles. A value of 0 is treated as 1.
- R8: stretch_err goes to 1 when the clock line stays low for cfg_stretch_limit cycles or more while the engine is waiting for it to rise. It holds until the next accepted command clears it. A limit of 0 disables the flag.
- R9: Out of reset (rst_n low, synchronous), both line enables are 0 (released), busy = 0, done = 0 and stretch_err = 0.
- R10: busy is 1 from the cycle after a command is accepted until the command completes. done is a single-cycle pulse in the cycle busy returns to 0. Commands are accepted only while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_half_div | input | DIV_W | Clock cycles per low or high phase of a bit |
| cfg_stretch_limit | input | TO_W | Stretch watchdog limit in cycles, 0 disables it |
| cmd_valid | input | 1 | Command strobe, taken when busy is 0 |
| cmd_op | input | 2 | 0 start, 1 stop, 2 write byte, 3 read byte |
| cmd_wdata | input | 8 | Byte to write |
| cmd_rd_nack | input | 1 | On a read: 1 answers not-acknowledge, 0 answers acknowledge |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read |
| ack_nack | output | 1 | Acknowledge bit sampled after the last write, 1 means not acknowledged |
| stretch_err | output | 1 | Clock held low beyond the limit |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| scl_in | input | 1 | Clock line level |
| sda_in | input | 1 | Data line level |

## Verification
The bench models a slave on a wired-AND bus. That slave holds the clock low for longer than a half period at chosen falling edges. If the high-phase timer started at the release instead of at the observed rise, the bench would measure high phases shorter than cfg_half_div. If the engine lost its place during a stretch, the written byte or the acknowledge would be corrupted. The bench counts start and stop events on the lines and compares them against the commands issued, which catches any data-line change while the clock is high during a byte. It also checks that the ninth-clock level on reads follows cmd_rd_nack, and that the watchdog flag is set past the limit, stays clear when the limit is 0, and clears on the next command.

// File: rtl/i2cm_pkg.sv
// Shared types for the byte-level two-wire master.
// Assumes: command codes are fixed by the host interface (0..3).
package i2cm_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } i2cm_op_e;

    typedef enum logic [3:0] {
        S_WAIT,
        S_ST_SETUP,
        S_ST_RISE,
        S_ST_HOLD,
        S_ST_FALL,
        S_SP_SETUP,
        S_SP_RISE,
        S_SP_HOLD,
        S_SP_FREE,
        S_B_LOW,
        S_B_RISE,
        S_B_HIGH
    } i2cm_state_e;

    localparam int BITS_PER_BYTE = 8;

endpackage

// File: rtl/i2cm_sync.sv
// Multi-stage synchronizer for asynchronous line inputs.
// Assumes: STAGES >= 2; the lines idle high, so every stage resets to 1.
module i2cm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] ff;

        // Shift one line level through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) ff <= '1;
            else        ff <= {ff[STAGES-2:0], d[g]};
        end

        assign q[g] = ff[STAGES-1];
    end

endmodule

// File: rtl/i2cm_phase_timer.sv
// Down-counter for one bit phase. Loads a length and counts down while run is high.
// Assumes: the caller ignores expired in the cycle it pulses load.
module i2cm_phase_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    input  logic         run,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Load a new phase length or count the running one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (load)                cnt <= len;
        else if (run && cnt != '0)    cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);

    // R6: with run low the count is frozen (stretch wait keeps the phase)
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(cnt));

    // R7: a load always leaves a nonzero count to run out
    p_load_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && len != '0) |=> !expired);

endmodule

// File: rtl/i2cm_stretch_wd.sv
// Watchdog on a held-low clock line while the master waits for it to rise.
// Assumes: limit == 0 disables the flag; clear has priority over setting.
module i2cm_stretch_wd #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         waiting,
    input  logic         line_low,
    input  logic [W-1:0] limit,
    input  logic         clear,
    output logic         err
);

    logic [W-1:0] cnt;
    logic         held;

    assign held = waiting && line_low;

    // Count consecutive held-low cycles, saturating at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || !held) cnt <= '0;
        else if (cnt != '1)  cnt <= cnt + W'(1);
    end

    // Raise the sticky flag past the limit; drop it on a new command.
    always_ff @(posedge clk) begin
        if (!rst_n)                                err <= 1'b0;
        else if (clear)                            err <= 1'b0;
        else if (held && limit != '0 && cnt >= limit) err <= 1'b1;
    end

    // R8: the flag stays set until cleared
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clear) |=> err);

    // R8: the counter restarts whenever the line is not held
    p_cnt_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !held |=> (cnt == '0));

endmodule

// File: rtl/i2c_stretch_master.sv
// Byte-level two-wire bus master with clock-stretch wait.
// Executes start, stop, byte write and byte read commands on open-drain lines.
// Whenever it releases the clock line it waits for the synchronized line to
// read high before timing the high phase, so a slave holding the clock low
// freezes the bit period. Assumes: the host waits for done between commands,
// and external pull-ups bring released lines high.
module i2c_stretch_master
    import i2cm_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int TO_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_half_div,
    input  logic [TO_W-1:0]  cfg_stretch_limit,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [7:0]       cmd_wdata,
    input  logic             cmd_rd_nack,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rd_data,
    output logic             ack_nack,
    output logic             stretch_err,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             scl_in,
    input  logic             sda_in
);

    localparam int                BIT_W    = $clog2(BITS_PER_BYTE + 1);
    localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(BITS_PER_BYTE);

    i2cm_state_e          state;
    i2cm_op_e             op;
    logic [BIT_W-1:0]     bit_cnt;
    logic [7:0]           shreg;
    logic                 rd_nack_q;
    logic                 scl_drv;
    logic                 sda_drv;
    logic                 tmr_load;
    logic                 tmr_exp;
    logic                 scl_s;
    logic                 sda_s;
    logic                 accept;
    logic                 in_rise;
    logic                 tmr_run;
    logic                 phase_end;
    logic [DIV_W-1:0]     half_len;

    // Data-line pull for one bit slot: data bits on write, acknowledge on read.
    function automatic logic slot_pull(i2cm_op_e o, logic is_ack, logic msb, logic nack);
        if (o == OP_WRITE) return is_ack ? 1'b0 : !msb;
        else               return is_ack ? !nack : 1'b0;
    endfunction

    i2cm_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     ({scl_s, sda_s})
    );

    assign half_len  = (cfg_half_div == '0) ? DIV_W'(1) : cfg_half_div;
    assign in_rise   = (state == S_ST_RISE) || (state == S_SP_RISE) || (state == S_B_RISE);
    assign tmr_run   = !in_rise && (state != S_WAIT);
    assign phase_end = tmr_exp && !tmr_load;
    assign accept    = (state == S_WAIT) && cmd_valid;

    i2cm_phase_timer #(
        .W (DIV_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (half_len),
        .run     (tmr_run),
        .expired (tmr_exp)
    );

    i2cm_stretch_wd #(
        .W (TO_W)
    ) u_wd (
        .clk      (clk),
        .rst_n    (rst_n),
        .waiting  (in_rise),
        .line_low (!scl_s),
        .limit    (cfg_stretch_limit),
        .clear    (accept),
        .err      (stretch_err)
    );

    // Command sequencer: walks the line phases of each command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_WAIT;
            op        <= OP_START;
            bit_cnt   <= '0;
            shreg     <= '0;
            rd_nack_q <= 1'b0;
            rd_data   <= '0;
            ack_nack  <= 1'b0;
            scl_drv   <= 1'b0;
            sda_drv   <= 1'b0;
            tmr_load  <= 1'b0;
            done      <= 1'b0;
        end else begin
            tmr_load <= 1'b0;
            done     <= 1'b0;
            unique case (state)
                S_WAIT: begin
                    if (cmd_valid) begin
                        op       <= i2cm_op_e'(cmd_op);
                        tmr_load <= 1'b1;
                        unique case (i2cm_op_e'(cmd_op))
                            OP_START: begin
                                sda_drv <= 1'b0;
                                state   <= S_ST_SETUP;
                            end
                            OP_STOP: begin
                                scl_drv <= 1'b1;
                                sda_drv <= 1'b1;
                                state   <= S_SP_SETUP;
                            end
                            default: begin
                                bit_cnt   <= '0;
                                rd_nack_q <= cmd_rd_nack;
                                shreg     <= (cmd_op == OP_WRITE) ? cmd_wdata : 8'h00;
                                scl_drv   <= 1'b1;
                                sda_drv   <= slot_pull(i2cm_op_e'(cmd_op), 1'b0,
                                                       cmd_wdata[7], cmd_rd_nack);
                                state     <= S_B_LOW;
                            end
                        endcase
                    end
                end
                S_ST_SETUP: if (phase_end) begin
                    scl_drv <= 1'b0;
                    state   <= S_ST_RISE;
                end
                S_ST_RISE: if (scl_s) begin
                    tmr_load <= 1'b1;
                    state    <= S_ST_HOLD;
                end
                S_ST_HOLD: if (phase_end) begin
                    sda_drv  <= 1'b1;
                    tmr_load <= 1'b1;
                    state    <= S_ST_FALL;
                end
                S_ST_FALL: if (phase_end) begin
                    scl_drv <= 1'b1;
                    done    <= 1'b1;
                    state   <= S_WAIT;
                end
                S_SP_SETUP: if (phase_end) begin
                    scl_drv <= 1'b0;
                    state   <= S_SP_RISE;
                end
                S_SP_RISE: if (scl_s) begin
                    tmr_load <= 1'b1;
                    state    <= S_SP_HOLD;
                end
                S_SP_HOLD: if (phase_end) begin
                    sda_drv  <= 1'b0;
                    tmr_load <= 1'b1;
                    state    <= S_SP_FREE;
                end
                S_SP_FREE: if (phase_end) begin
                    done  <= 1'b1;
                    state <= S_WAIT;
                end
                S_B_LOW: if (phase_end) begin
                    scl_drv <= 1'b0;
                    state   <= S_B_RISE;
                end
                S_B_RISE: if (scl_s) begin
                    tmr_load <= 1'b1;
                    state    <= S_B_HIGH;
                end
                S_B_HIGH: if (phase_end) begin
                    scl_drv <= 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        if (op == OP_WRITE) ack_nack <= sda_s;
                        else                rd_data  <= shreg;
                        sda_drv <= 1'b0;
                        done    <= 1'b1;
                        state   <= S_WAIT;
                    end else begin
                        shreg    <= {shreg[6:0], sda_s};
                        bit_cnt  <= bit_cnt + BIT_W'(1);
                        sda_drv  <= slot_pull(op, (bit_cnt + BIT_W'(1)) == LAST_BIT,
                                              shreg[6], rd_nack_q);
                        tmr_load <= 1'b1;
                        state    <= S_B_LOW;
                    end
                end
                default: state <= S_WAIT;
            endcase
        end
    end

    assign busy   = (state != S_WAIT);
    assign scl_oe = scl_drv;
    assign sda_oe = sda_drv;

    // R6: the clock line stays released while waiting for it to rise
    p_release_in_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_rise |-> !scl_drv);

    // R5: the data line is steady through a bit's high phase
    p_sda_steady_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_B_HIGH) |-> $stable(sda_drv));

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done coincides with leaving busy
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R1: the slot counter never passes the acknowledge slot
    p_slot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= LAST_BIT);

    // R4: after a byte the clock line is held low
    p_hold_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op == OP_WRITE || op == OP_READ)) |-> scl_drv);

endmodule

// File: tb/i2c_stretch_master_tb.sv
module i2c_stretch_master_tb_top;

    localparam int MODE_IDLE   = 0;
    localparam int MODE_LISTEN = 1;
    localparam int MODE_TX     = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_half_div;
    logic [15:0] cfg_stretch_limit;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [7:0]  cmd_wdata;
    logic        cmd_rd_nack;
    logic        busy, done, ack_nack, stretch_err, scl_oe, sda_oe;
    logic [7:0]  rd_data;

    logic        slv_scl_low;
    logic        slv_sda_low;
    wire         scl_bus = !(scl_oe || slv_scl_low);
    wire         sda_bus = !(sda_oe || slv_sda_low);

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          finished = 0;

    int          slv_mode = MODE_IDLE;
    logic        slv_ack  = 1'b1;
    logic [7:0]  tx_byte  = 8'h00;
    int          stretch_len = 0;
    int          arm_req = 0, arm_ack = 0;
    int          seg_req = 0, seg_ack = 0;

    int          bc = 0;
    bit          first_fall = 0;
    logic        prev_scl = 1'b1, prev_sda = 1'b1;
    int          hi_cnt = 0, lo_cnt = 0, str_cnt = 0;
    int          min_high = 1000000, min_low = 1000000;
    int          n_start = 0, n_stop = 0;
    logic [8:0]  cap = '0;

    always #10 clk = ~clk;

    i2c_stretch_master dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg_half_div      (cfg_half_div),
        .cfg_stretch_limit (cfg_stretch_limit),
        .cmd_valid         (cmd_valid),
        .cmd_op            (cmd_op),
        .cmd_wdata         (cmd_wdata),
        .cmd_rd_nack       (cmd_rd_nack),
        .busy              (busy),
        .done              (done),
        .rd_data           (rd_data),
        .ack_nack          (ack_nack),
        .stretch_err       (stretch_err),
        .scl_oe            (scl_oe),
        .sda_oe            (sda_oe),
        .scl_in            (scl_bus),
        .sda_in            (sda_bus)
    );

    // Slave data drive: acknowledge in listen mode, byte bits in transmit mode.
    always_comb begin
        slv_sda_low = 1'b0;
        if (slv_mode == MODE_LISTEN)  slv_sda_low = (bc == 8) && slv_ack;
        else if (slv_mode == MODE_TX) slv_sda_low = (bc < 8) && !tx_byte[7 - bc];
    end

    assign slv_scl_low = (str_cnt != 0);

    // Bus monitor and slave clock stretcher, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_scl = 1'b1; prev_sda = 1'b1; bc = 0; first_fall = 0;
            hi_cnt = 0; lo_cnt = 0; str_cnt = 0;
        end else begin
            if (seg_req != seg_ack) begin
                seg_ack = seg_req; min_high = 1000000; min_low = 1000000;
            end
            if (str_cnt > 0) str_cnt = str_cnt - 1;
            if (prev_scl && scl_bus && prev_sda && !sda_bus) begin
                n_start = n_start + 1; bc = 0; first_fall = 1;
            end
            if (prev_scl && scl_bus && !prev_sda && sda_bus) n_stop = n_stop + 1;
            if (!prev_scl && scl_bus) begin
                cap[bc] = sda_bus;
                if (lo_cnt < min_low) min_low = lo_cnt;
                lo_cnt = 0;
            end
            if (prev_scl && !scl_bus) begin
                if (hi_cnt < min_high) min_high = hi_cnt;
                hi_cnt = 0;
                if (first_fall) first_fall = 0;
                else bc = (bc == 8) ? 0 : bc + 1;
                if (arm_req != arm_ack) begin
                    arm_ack = arm_req; str_cnt = stretch_len;
                end
            end
            if (scl_bus) hi_cnt = hi_cnt + 1;
            else         lo_cnt = lo_cnt + 1;
            prev_scl = scl_bus;
            prev_sda = sda_bus;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cap_byte(input logic [8:0] c);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) b[7 - i] = c[i];
        return b;
    endfunction

    task automatic do_cmd(input logic [1:0] op, input logic [7:0] d, input logic nack);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d; cmd_rd_nack = nack;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        while (!done) @(negedge clk);
        chk(busy == 1'b0, "R10 busy low with done", busy, 0);
    endtask

    task automatic bus_start();
        int s0 = n_start, p0 = n_stop;
        do_cmd(2'd0, 8'h00, 1'b0);
        chk(n_start == s0 + 1 && n_stop == p0, "R5 start event", n_start - s0, 1);
    endtask

    task automatic bus_stop();
        int s0 = n_start, p0 = n_stop;
        slv_mode = MODE_IDLE;
        do_cmd(2'd1, 8'h00, 1'b0);
        chk(n_stop == p0 + 1 && n_start == s0, "R5 stop event", n_stop - p0, 1);
    endtask

    task automatic byte_write(input logic [7:0] d, input logic ack, input int str);
        int s0 = n_start, p0 = n_stop;
        slv_mode = MODE_LISTEN; slv_ack = ack;
        if (str > 0) begin stretch_len = str; arm_req = arm_req + 1; end
        do_cmd(2'd2, d, 1'b0);
        chk(cap_byte(cap) == d, "R1 write byte on bus", cap_byte(cap), d);
        chk(ack_nack == !ack, "R2 ack status", ack_nack, !ack);
        chk(n_start == s0 && n_stop == p0, "R5 no event in byte", n_start + n_stop, s0 + p0);
        chk(scl_oe == 1'b1, "R4 clock held low after byte", scl_oe, 1);
        slv_mode = MODE_IDLE;
    endtask

    task automatic byte_read(input logic [7:0] d, input logic nack, input int str);
        slv_mode = MODE_TX; tx_byte = d;
        if (str > 0) begin stretch_len = str; arm_req = arm_req + 1; end
        do_cmd(2'd3, 8'h00, nack);
        slv_mode = MODE_IDLE;
        chk(rd_data == d, "R3 read data", rd_data, d);
        chk(cap[8] == nack, "R3 master ack level", cap[8], nack);
    endtask

    task automatic check_timing(input int hd);
        chk(min_low >= hd, "R7 low phase length", min_low, hd);
        chk(min_high >= hd, "R6 high phase after rise", min_high, hd);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks = n_checks + 1; n_fail = n_fail + 1;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(20240611);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_wdata = 8'h00;
        cmd_rd_nack = 1'b0; cfg_half_div = 16'd4; cfg_stretch_limit = 16'd0;
        repeat (5) @(negedge clk);
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R9 lines released in reset", {scl_oe, sda_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R9 idle after reset", {busy, done}, 0);
        chk(stretch_err == 1'b0, "R9 no error after reset", stretch_err, 0);

        // Directed: alternating bit patterns, both ack answers.
        seg_req = seg_req + 1;
        bus_start();
        byte_write(8'hA5, 1'b1, 0);
        byte_write(8'h01, 1'b0, 0);
        byte_read(8'h80, 1'b0, 0);
        byte_read(8'h5A, 1'b1, 0);
        bus_stop();
        check_timing(4);

        // Directed: zero divider treated as one.
        cfg_half_div = 16'd0;
        seg_req = seg_req + 1;
        bus_start();
        byte_write(8'hFF, 1'b1, 0);
        bus_stop();
        check_timing(1);

        // Directed: long stretch during a write and a read, watchdog disabled.
        cfg_half_div = 16'd5;
        seg_req = seg_req + 1;
        bus_start();
        byte_write(8'hC3, 1'b1, 40);
        chk(stretch_err == 1'b0, "R8 limit zero disables", stretch_err, 0);
        byte_read(8'h3C, 1'b0, 25);
        byte_write(8'h00, 1'b1, 0);
        bus_stop();
        check_timing(5);

        // Directed: repeated start inside a transfer.
        seg_req = seg_req + 1;
        bus_start();
        byte_write(8'h92, 1'b1, 0);
        bus_start();
        byte_read(8'h6D, 1'b1, 0);
        bus_stop();
        check_timing(5);

        // Directed: watchdog fires past the limit and clears on the next command.
        cfg_half_div = 16'd3; cfg_stretch_limit = 16'd8;
        bus_start();
        chk(stretch_err == 1'b0, "R8 short wait no error", stretch_err, 0);
        byte_write(8'h4B, 1'b1, 40);
        chk(stretch_err == 1'b1, "R8 error after long hold", stretch_err, 1);
        bus_stop();
        chk(stretch_err == 1'b0, "R8 error cleared by command", stretch_err, 0);
        cfg_stretch_limit = 16'd0;

        // Random transfers: divider, byte count, direction, ack and stretch.
        for (int t = 0; t < 30; t++) begin
            int hd, nb;
            hd = 2 + int'($urandom_range(0, 5));
            nb = 1 + int'($urandom_range(0, 4));
            cfg_half_div = 16'(hd);
            seg_req = seg_req + 1;
            bus_start();
            for (int b = 0; b < nb; b++) begin
                logic [7:0] v;
                int str;
                v = 8'($urandom);
                str = ($urandom_range(0, 3) == 0) ? int'($urandom_range(hd + 2, 30)) : 0;
                if ($urandom_range(0, 1) == 1) byte_write(v, 1'($urandom), str);
                else                           byte_read(v, 1'($urandom), str);
            end
            bus_stop();
            check_timing(hd);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule